// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block searches and grows the chain of extended capability headers that lives in the upper part of a 4 KB configuration space. The space sits in a single-port RAM outside the block, reached through a word-wide read/write port with one cycle of read latency. A search takes a 16-bit capability identifier. It follows the next pointers from the fixed chain head at byte offset 0x100 and reports the offset of the matching header together with the offset visited just before it. Identifier 0 is reserved as a "find the tail" key, so a search for it always runs to the last header of the chain.

An append writes a new header at a caller-chosen offset. When that offset is the chain head, the header there is rewritten in place and keeps its existing next pointer. Anywhere else, the block first walks to the tail, patches the tail's next pointer to the new offset and then writes the new header with a null next pointer. A request is one `start` pulse, and its outcome is reported with a one-cycle `done` pulse. Broken chains are reported with error codes: misaligned or out-of-window next pointers, cycles that exceed the hop bound, bad append arguments, and an append to a chain that has no head.

Top module: `xcap_chain_walker`

## Requirements
- R1: A header word holds the identifier in bits 15:0, the version in bits 19:16 and the next byte offset in bits 31:20. A walk starts at offset 0x100 and issues exactly one memory read per header visited. No two reads are issued in back-to-back cycles.
- R2: A search whose key matches a header's identifier returns `hit_off` = that header's offset and `prev_off` = the offset visited before it (0 when the match is at 0x100). A match wins over a null next pointer in the same header.
- R3: A search that reaches a header with next pointer 0 without a match returns `hit_off` = 0 and `prev_off` = the offset of that last header, with no error.
- R4: If the header at 0x100 reads as all zeros, a search returns `hit_off` = 0 and `prev_off` = 0 with no error, after a single read.
- R5: Key 0 never matches, even a header whose identifier field is 0, so a search for 0 returns the chain's tail in `prev_off`.
- R6: A next pointer whose two low bits are not 00 ends the operation with error code 1. This check takes priority over the window check.
- R7: A next pointer below 0x100 or above 0xFF8 ends the operation with error code 2. A read is never issued outside the word window 0x100..0xFF8, and a header at 0xFF8 itself is legal.
- R8: When MAX_HOPS headers have been read and the last one neither matches nor ends the chain, the operation ends with error code 3 after exactly MAX_HOPS reads.
- R9: An append at an offset other than 0x100 rewrites the tail header with its next field set to the new offset and its identifier and version kept. It then writes {next=0, version, identifier} at the new offset and returns `hit_off` = the new offset and `prev_off` = the old tail. There are exactly two writes.
- R10: An append at 0x100 reads the head once and writes {old next, new version, new identifier} there. It returns `hit_off` = 0x100 and `prev_off` = 0 with a single write.
- R11: An append whose offset is misaligned or below 0x100, whose size is below 8, or whose offset plus size is not below 4096 ends with error code 4 on the cycle after `start`, with no memory access. An append at a non-head offset to an empty chain ends with error code 5 and no write.
- R12: After reset `done`, `err`, `hit_off`, `prev_off` and both memory strobes are 0. `done` is a one-cycle pulse, `err` is 1 exactly when the code is non-zero, and a `start` that arrives while an operation is running is ignored.
- R13: `mem_rd` and `mem_wr` are never asserted in the same cycle, and writes occur only during an append.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| op_append | input | 1 | 1 = append, 0 = search |
| key_id | input | 16 | Search key, or identifier of the appended header |
| new_ver | input | 4 | Version of the appended header |
| new_off | input | 12 | Byte offset of the appended header |
| new_size | input | 13 | Byte size of the appended capability region |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Operation ended with an error |
| err_code | output | 3 | 0 none, 1 misaligned, 2 out of window, 3 hop bound, 4 bad append arguments, 5 empty chain |
| hit_off | output | 12 | Matching or appended offset, 0 if none |
| prev_off | output | 12 | Offset visited before the hit, or the tail |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 10 | Word address (byte offset / 4) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |

## Verification
Match detection and end-of-chain detection are judged on the same header in the same cycle. The bench provokes this with a single-header chain and with searches for the last identifier of longer chains, and it judges the outcome by `hit_off` carrying the header's offset rather than 0. A second collision is a new `start` arriving while a walk is in the middle of the chain. It is provoked with a conflicting append request, and it is judged by the result, the read count and the memory contents, which must all match the original search alone. Random chains, with random keys, absent keys, tail lookups and appends, are compared against a bench model of the chain.

// File: rtl/xcw_pkg.sv
`timescale 1ns/1ps
package xcw_pkg;
    localparam int ID_W  = 16;
    localparam int VER_W = 4;
    localparam int PTR_W = 12;

    typedef struct packed {
        logic [PTR_W-1:0] nxt;
        logic [VER_W-1:0] ver;
        logic [ID_W-1:0]  id;
    } cap_hdr_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ, ST_CHECK, ST_PATCH, ST_WRITE
    } walk_state_e;

    typedef enum logic [2:0] {
        E_NONE   = 3'd0,
        E_ALIGN  = 3'd1,
        E_RANGE  = 3'd2,
        E_LOOP   = 3'd3,
        E_ARGS   = 3'd4,
        E_NOHEAD = 3'd5
    } walk_err_e;
endpackage

// File: rtl/xcw_ptr_check.sv
`timescale 1ns/1ps
// Splits a fetched header and judges its next pointer.
module xcw_ptr_check import xcw_pkg::*; #(
    parameter int CFG_BYTES = 4096,
    parameter int EXT_BASE  = 256
) (
    input  logic [31:0]      word_i,
    output logic [ID_W-1:0]  id_o,
    output logic [PTR_W-1:0] nxt_o,
    output logic             all_zero_o,
    output logic             bad_align_o,
    output logic             bad_range_o
);
    localparam logic [PTR_W-1:0] LO_P = PTR_W'(EXT_BASE);
    localparam logic [PTR_W-1:0] HI_P = PTR_W'(CFG_BYTES - 8);

    cap_hdr_t hdr;

    always_comb begin
        hdr         = cap_hdr_t'(word_i);
        id_o        = hdr.id;
        nxt_o       = hdr.nxt;
        all_zero_o  = (word_i == 32'h0);
        bad_align_o = (hdr.nxt[1:0] != 2'b00);
        bad_range_o = (hdr.nxt < LO_P) || (hdr.nxt > HI_P);
    end
endmodule

// File: rtl/xcw_arg_check.sv
`timescale 1ns/1ps
// Validates the placement of an appended capability region.
module xcw_arg_check #(
    parameter int CFG_BYTES = 4096,
    parameter int EXT_BASE  = 256,
    parameter int OFF_W     = 12
) (
    input  logic [OFF_W-1:0] off_i,
    input  logic [OFF_W:0]   size_i,
    output logic             ok_o
);
    localparam int SUM_W = OFF_W + 2;
    localparam logic [OFF_W-1:0] LO_P   = OFF_W'(EXT_BASE);
    localparam logic [OFF_W:0]   MIN_SZ = (OFF_W+1)'(8);
    localparam logic [SUM_W-1:0] END_P  = SUM_W'(CFG_BYTES);

    logic [SUM_W-1:0] span_end;

    always_comb begin
        span_end = {2'b00, off_i} + {1'b0, size_i};
        ok_o     = (off_i[1:0] == 2'b00) && (off_i >= LO_P) &&
                   (size_i >= MIN_SZ) && (span_end < END_P);
    end
endmodule

// File: rtl/xcw_hop_limit.sv
`timescale 1ns/1ps
// Counts followed pointers and flags the last permitted header.
module xcw_hop_limit #(
    parameter int MAX_HOPS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic at_limit_o
);
    localparam int CW = $clog2(MAX_HOPS + 1);
    localparam logic [CW-1:0] LAST = CW'(MAX_HOPS - 1);

    logic [CW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clear_i)     count_d = '0;
        else if (step_i) count_d = count_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign at_limit_o = (count_q == LAST);
endmodule

// File: rtl/xcap_chain_walker.sv
`timescale 1ns/1ps
// Walks and extends the extended-capability chain in configuration RAM.
module xcap_chain_walker import xcw_pkg::*; #(
    parameter int CFG_BYTES = 4096,
    parameter int EXT_BASE  = 256,
    parameter int MAX_HOPS  = 1024
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          op_append,
    input  logic [15:0]                   key_id,
    input  logic [3:0]                    new_ver,
    input  logic [$clog2(CFG_BYTES)-1:0]  new_off,
    input  logic [$clog2(CFG_BYTES):0]    new_size,
    output logic                          done,
    output logic                          err,
    output logic [2:0]                    err_code,
    output logic [$clog2(CFG_BYTES)-1:0]  hit_off,
    output logic [$clog2(CFG_BYTES)-1:0]  prev_off,
    output logic                          mem_rd,
    output logic                          mem_wr,
    output logic [$clog2(CFG_BYTES)-3:0]  mem_addr,
    output logic [31:0]                   mem_wdata,
    input  logic [31:0]                   mem_rdata
);
    localparam int OFF_W = $clog2(CFG_BYTES);
    localparam int AW    = OFF_W - 2;
    localparam logic [OFF_W-1:0] BASE_OFF = OFF_W'(EXT_BASE);

    typedef struct packed {
        walk_state_e      st;
        logic             app;
        logic [ID_W-1:0]  key;
        logic [ID_W-1:0]  nid;
        logic [VER_W-1:0] ver;
        logic [OFF_W-1:0] noff;
        logic [OFF_W-1:0] cur;
        logic [OFF_W-1:0] prev;
        cap_hdr_t         hdr;
        logic             done;
        logic             err;
        walk_err_e        code;
        logic [OFF_W-1:0] hit;
        logic [OFF_W-1:0] pout;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic [ID_W-1:0]  f_id;
    logic [PTR_W-1:0] f_nxt;
    logic             f_zero, f_misal, f_range;
    logic             args_ok, hop_last, hop_clear, hop_step;
    logic [PTR_W-1:0] keep_nxt;

    xcw_ptr_check #(.CFG_BYTES(CFG_BYTES), .EXT_BASE(EXT_BASE)) u_ptr (
        .word_i      (mem_rdata),
        .id_o        (f_id),
        .nxt_o       (f_nxt),
        .all_zero_o  (f_zero),
        .bad_align_o (f_misal),
        .bad_range_o (f_range)
    );

    xcw_arg_check #(.CFG_BYTES(CFG_BYTES), .EXT_BASE(EXT_BASE), .OFF_W(OFF_W)) u_args (
        .off_i  (new_off),
        .size_i (new_size),
        .ok_o   (args_ok)
    );

    xcw_hop_limit #(.MAX_HOPS(MAX_HOPS)) u_hops (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (hop_clear),
        .step_i     (hop_step),
        .at_limit_o (hop_last)
    );

    function automatic walk_regs_t finish(input walk_regs_t r, input walk_err_e c,
                                          input logic [OFF_W-1:0] h,
                                          input logic [OFF_W-1:0] p);
        walk_regs_t o;
        o      = r;
        o.st   = ST_IDLE;
        o.done = 1'b1;
        o.err  = (c != E_NONE);
        o.code = c;
        o.hit  = h;
        o.pout = p;
        return o;
    endfunction

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        hop_clear = 1'b0;
        hop_step  = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = r_q.cur[OFF_W-1:2];
        mem_wdata = '0;
        keep_nxt  = (r_q.noff == BASE_OFF) ? r_q.hdr.nxt : PTR_W'(0);

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    hop_clear = 1'b1;
                    r_d.app   = op_append;
                    r_d.key   = op_append ? '0 : key_id;
                    r_d.nid   = key_id;
                    r_d.ver   = new_ver;
                    r_d.noff  = new_off;
                    r_d.cur   = BASE_OFF;
                    r_d.prev  = '0;
                    if (op_append && !args_ok) r_d = finish(r_d, E_ARGS, '0, '0);
                    else                       r_d.st = ST_READ;
                end
            end
            ST_READ: begin
                mem_rd = 1'b1;
                r_d.st = ST_CHECK;
            end
            ST_CHECK: begin
                r_d.hdr = cap_hdr_t'(mem_rdata);
                if (r_q.app && r_q.noff == BASE_OFF) begin
                    r_d.st = ST_WRITE;
                end else if (r_q.cur == BASE_OFF && f_zero) begin
                    r_d = r_q.app ? finish(r_d, E_NOHEAD, '0, '0)
                                  : finish(r_d, E_NONE, '0, '0);
                end else if (!r_q.app && r_q.key != '0 && f_id == r_q.key) begin
                    r_d = finish(r_d, E_NONE, r_q.cur, r_q.prev);
                end else if (f_nxt == '0) begin
                    if (r_q.app) begin
                        r_d.prev = r_q.cur;
                        r_d.st   = ST_PATCH;
                    end else begin
                        r_d = finish(r_d, E_NONE, '0, r_q.cur);
                    end
                end else if (f_misal) begin
                    r_d = finish(r_d, E_ALIGN, '0, '0);
                end else if (f_range) begin
                    r_d = finish(r_d, E_RANGE, '0, '0);
                end else if (hop_last) begin
                    r_d = finish(r_d, E_LOOP, '0, '0);
                end else begin
                    hop_step = 1'b1;
                    r_d.prev = r_q.cur;
                    r_d.cur  = f_nxt;
                    r_d.st   = ST_READ;
                end
            end
            ST_PATCH: begin
                mem_wr    = 1'b1;
                mem_addr  = r_q.prev[OFF_W-1:2];
                mem_wdata = {r_q.noff, r_q.hdr.ver, r_q.hdr.id};
                r_d.st    = ST_WRITE;
            end
            ST_WRITE: begin
                mem_wr    = 1'b1;
                mem_addr  = r_q.noff[OFF_W-1:2];
                mem_wdata = {keep_nxt, r_q.ver, r_q.nid};
                r_d = finish(r_d, E_NONE, r_q.noff,
                             (r_q.noff == BASE_OFF) ? '0 : r_q.prev);
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done     = r_q.done;
    assign err      = r_q.err;
    assign err_code = r_q.code;
    assign hit_off  = r_q.hit;
    assign prev_off = r_q.pout;
endmodule

// File: rtl/xcw_checker.sv
`timescale 1ns/1ps
module xcw_checker #(
    parameter int CFG_BYTES = 4096,
    parameter int EXT_BASE  = 256
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          done,
    input logic                          err,
    input logic [2:0]                    err_code,
    input logic [$clog2(CFG_BYTES)-1:0]  hit_off,
    input logic [$clog2(CFG_BYTES)-1:0]  prev_off,
    input logic                          mem_rd,
    input logic                          mem_wr,
    input logic [$clog2(CFG_BYTES)-3:0]  mem_addr,
    input logic                          app_latched
);
    localparam int AW = $clog2(CFG_BYTES) - 2;
    localparam logic [AW-1:0] WLO = AW'(EXT_BASE / 4);
    localparam logic [AW-1:0] WHI = AW'((CFG_BYTES - 8) / 4);

    assert_strobe_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)) else $error("read and write strobes together");

    assert_write_in_append_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> app_latched) else $error("write outside an append");

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done wider than one cycle");

    assert_err_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err == (err_code != 3'd0))) else $error("err and code disagree");

    assert_read_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr >= WLO && mem_addr <= WHI)) else $error("read outside window");

    assert_read_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd) else $error("back-to-back reads");

    assert_ok_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (hit_off[1:0] == 2'b00 && prev_off[1:0] == 2'b00))
        else $error("unaligned result offset");
endmodule

bind xcap_chain_walker xcw_checker #(.CFG_BYTES(CFG_BYTES), .EXT_BASE(EXT_BASE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done),
    .err         (err),
    .err_code    (err_code),
    .hit_off     (hit_off),
    .prev_off    (prev_off),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_addr    (mem_addr),
    .app_latched (r_q.app)
);

// File: tb/test_xcap_chain_walker.sv
`timescale 1ns/1ps
module test_xcap_chain_walker;
    localparam int HOPS = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, op_append = 1'b0;
    logic [15:0] key_id = '0;
    logic [3:0]  new_ver = '0;
    logic [11:0] new_off = '0;
    logic [12:0] new_size = '0;
    logic        done, err, mem_rd, mem_wr;
    logic [2:0]  err_code;
    logic [11:0] hit_off, prev_off;
    logic [9:0]  mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    logic [31:0] mem    [0:1023];
    logic [31:0] shadow [0:1023];
    int rd_cnt = 0, wr_cnt = 0;
    int errs = 0, checks = 0;
    logic [11:0] g_hit, g_prev;
    logic        g_err;
    logic [2:0]  g_code;
    int g_rd, g_wr;
    logic [11:0] lst_off [0:7];
    logic [15:0] lst_id  [0:7];
    bit summary_done = 0;

    always #2.5 clk = ~clk;

    xcap_chain_walker #(.CFG_BYTES(4096), .EXT_BASE(256), .MAX_HOPS(HOPS)) i_xcap_chain_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .op_append(op_append),
        .key_id(key_id), .new_ver(new_ver), .new_off(new_off), .new_size(new_size),
        .done(done), .err(err), .err_code(err_code), .hit_off(hit_off),
        .prev_off(prev_off), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_rd) rd_cnt <= rd_cnt + 1;
        if (mem_wr) wr_cnt <= wr_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic scrub();
        for (int i = 0; i < 1024; i++) mem[i] = $urandom;
        mem[64] = 32'h0;
    endtask

    task automatic put(input logic [11:0] off, input logic [11:0] nxt, input logic [3:0] ver, input logic [15:0] id);
        mem[off >> 2] = {nxt, ver, id};
    endtask

    // Bench model of a chain search (R1..R8).
    function automatic void ref_find(input logic [15:0] key, output logic [11:0] h,
                                     output logic [11:0] p, output logic [2:0] c, output int reads);
        logic [11:0] cur = 12'h100, prv = 12'h0, nx;
        logic [31:0] w;
        int hops = 1;
        h = '0; p = '0; c = '0; reads = 1;
        w = mem[cur >> 2];
        if (w == 32'h0) return;
        while (1) begin
            nx = w[31:20];
            if (key != 16'h0 && w[15:0] == key) begin h = cur; p = prv; return; end
            if (nx == 12'h0) begin p = cur; return; end
            if (nx[1:0] != 2'b00) begin c = 3'd1; return; end
            if (nx < 12'h100 || nx > 12'hFF8) begin c = 3'd2; return; end
            if (hops == HOPS) begin c = 3'd3; return; end
            prv = cur; cur = nx; hops++; reads++;
            w = mem[cur >> 2];
        end
    endfunction

    task automatic run_op(input bit app, input logic [15:0] id, input logic [3:0] ver,
                          input logic [11:0] off, input logic [12:0] sz, input bit poke);
        int rd0, wr0, cyc;
        @(negedge clk);
        rd0 = rd_cnt; wr0 = wr_cnt;
        op_append = app; key_id = id; new_ver = ver; new_off = off; new_size = sz;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            if (!done) begin
                start = 1'b1; op_append = 1'b1; key_id = ~id; new_off = 12'hE00; new_size = 13'd16;
                @(negedge clk);
                start = 1'b0;
            end
        end
        cyc = 0;
        while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
        chk(cyc < 5000, "R12", "watchdog done", cyc, 0);
        g_hit = hit_off; g_prev = prev_off; g_err = err; g_code = err_code;
        @(negedge clk);
        chk(done == 1'b0, "R12", "done pulse width", done, 0);
        g_rd = rd_cnt - rd0; g_wr = wr_cnt - wr0;
    endtask

    task automatic do_find(input logic [15:0] key, input string req, input bit poke);
        logic [11:0] eh, ep; logic [2:0] ec; int er;
        ref_find(key, eh, ep, ec, er);
        run_op(1'b0, key, 4'h0, 12'h0, 13'h0, poke);
        chk(g_hit == eh, req, "hit_off", g_hit, eh);
        chk(g_prev == ep, req, "prev_off", g_prev, ep);
        chk(g_code == ec && g_err == (ec != 0), req, "err_code", g_code, ec);
        chk(g_rd == er, req, "reads R1", g_rd, er);
        chk(g_wr == 0, "R13", "writes in search", g_wr, 0);
    endtask

    task automatic do_append(input logic [15:0] id, input logic [3:0] ver, input logic [11:0] off,
                             input logic [12:0] sz, input string req);
        logic [11:0] eh, ep, th, tp; logic [2:0] ec, tc; int er, ew, tr, bad;
        bit ok;
        shadow = mem;
        ok = (off[1:0] == 2'b00) && (off >= 12'h100) && (sz >= 13'd8) && (int'(off) + int'(sz) < 4096);
        eh = '0; ep = '0; ec = '0; er = 0; ew = 0;
        if (!ok) ec = 3'd4;
        else if (off == 12'h100) begin
            er = 1; ew = 1; eh = off;
            shadow[64] = {shadow[64][31:20], ver, id};
        end else begin
            ref_find(16'h0, th, tp, tc, tr);
            er = tr;
            if (tc != 0) ec = tc;
            else if (tp == 12'h0) ec = 3'd5;
            else begin
                ew = 2; eh = off; ep = tp;
                shadow[tp >> 2] = {off, shadow[tp >> 2][19:0]};
                shadow[off >> 2] = {12'h0, ver, id};
            end
        end
        run_op(1'b1, id, ver, off, sz, 1'b0);
        chk(g_hit == eh, req, "append hit_off", g_hit, eh);
        chk(g_prev == ep, req, "append prev_off", g_prev, ep);
        chk(g_code == ec && g_err == (ec != 0), req, "append err_code", g_code, ec);
        chk(g_rd == er, req, "append reads", g_rd, er);
        chk(g_wr == ew, req, "append writes", g_wr, ew);
        bad = 0;
        for (int i = 0; i < 1024; i++) if (mem[i] !== shadow[i]) bad++;
        chk(bad == 0, req, "memory words differing", bad, 0);
    endtask

    task automatic build(input int n);
        logic [11:0] cur, nx;
        scrub();
        cur = 12'h100;
        for (int i = 0; i < n; i++) begin
            lst_off[i] = cur;
            lst_id[i]  = 16'((i + 1) << 8) | 16'($urandom % 256);
            nx = (i == n - 1) ? 12'h0 : cur + 12'd8 + 12'(4 * ($urandom % 32));
            put(cur, nx, 4'($urandom), lst_id[i]);
            cur = nx;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!summary_done) begin
            errs++;
            $display("FAIL R12 global watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        scrub();
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(done == 0 && err == 0, "R12", "reset done/err", {done, err}, 0);
        chk(hit_off == 0 && prev_off == 0, "R12", "reset offsets", hit_off, 0);
        chk(mem_rd == 0 && mem_wr == 0, "R12", "reset strobes", {mem_rd, mem_wr}, 0);
        rst_n = 1'b1;

        // R4: empty chain
        scrub(); do_find(16'h1234, "R4", 0);
        // R2 single header: match and end on same header; R3 miss; R5 tail
        scrub(); put(12'h100, 12'h0, 4'h1, 16'hA001);
        do_find(16'hA001, "R2", 0);
        do_find(16'h5555, "R3", 0);
        do_find(16'h0000, "R5", 0);
        // three headers, middle identifier 0
        scrub(); put(12'h100, 12'h180, 4'h1, 16'h0011); put(12'h180, 12'h300, 4'h2, 16'h0000);
        put(12'h300, 12'h0, 4'h3, 16'h0033);
        do_find(16'h0033, "R2", 0);
        do_find(16'h0000, "R5", 0);
        // R10: append at head keeps next, then R9 tail append
        do_append(16'hBEEF, 4'h3, 12'h100, 13'd8, "R10");
        do_append(16'hC0DE, 4'h5, 12'hE00, 13'd64, "R9");
        do_find(16'hC0DE, "R9", 0);
        // R11 arguments
        do_append(16'h1, 4'h1, 12'hE00, 13'd7, "R11");
        do_append(16'h1, 4'h1, 12'hF00, 13'd256, "R11");
        do_append(16'h1, 4'h1, 12'h0F0, 13'd16, "R11");
        do_append(16'h1, 4'h1, 12'hE02, 13'd16, "R11");
        do_append(16'h2, 4'h1, 12'hF00, 13'd255, "R9");
        scrub(); do_append(16'h3, 4'h1, 12'h200, 13'd16, "R11");
        // R6 misaligned, with priority over window
        scrub(); put(12'h100, 12'h182, 4'h0, 16'h0001); do_find(16'h0009, "R6", 0);
        put(12'h100, 12'h0FE, 4'h0, 16'h0001); do_find(16'h0009, "R6", 0);
        // R7 window bounds
        put(12'h100, 12'h0FC, 4'h0, 16'h0001); do_find(16'h0009, "R7", 0);
        put(12'h100, 12'hFFC, 4'h0, 16'h0001); do_find(16'h0009, "R7", 0);
        put(12'h100, 12'hFF8, 4'h0, 16'h0001); put(12'hFF8, 12'h0, 4'h0, 16'h0077);
        do_find(16'h0077, "R7", 0);
        // R8 cycles
        put(12'h100, 12'h100, 4'h0, 16'h0001); do_find(16'h0002, "R8", 0);
        put(12'h100, 12'h200, 4'h0, 16'h0001); put(12'h200, 12'h100, 4'h0, 16'h0003);
        do_append(16'h4, 4'h1, 12'hE00, 13'd8, "R8");
        // R12: start while busy ignored
        build(6); do_find(lst_id[5], "R12", 1);

        for (int it = 0; it < 40; it++) begin
            int n, mode;
            n = 1 + int'($urandom % 8);
            build(n);
            mode = int'($urandom % 5);
            case (mode)
                0: do_find(lst_id[$urandom % n], "R2", 0);
                1: do_find(16'hFF00 | 16'($urandom % 256), "R3", 0);
                2: do_find(16'h0000, "R5", 0);
                3: do_append(16'($urandom), 4'($urandom), 12'hE00 + 12'(4 * ($urandom % 64)),
                             13'd8 + 13'($urandom % 64), "R9");
                default: do_append(16'($urandom), 4'($urandom), 12'h100, 13'd8, "R10");
            endcase
        end

        summary_done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule